// File: doc/BRIEF.md
# Addressed SPI Slave Register Interface

This block is the host-facing register port of a mixed-signal companion device. A host controller acts as SPI master and supplies the serial clock. Through one fixed 24-bit frame it reads and writes read/write configuration words, reads status words and identification words, and reads or writes the memory that holds the converter results. The converter side writes its results into that memory through a separate parallel port.

A frame opens with a two-bit device address. This address is compared against a strap input, so up to four such devices can share a single slave-select line. A device whose address does not match keeps its serial output released for the whole frame and commits nothing. The serial inputs are oversampled by the block's own clock. SCK must therefore stay well below a quarter of that clock. At a 50 MHz system clock, transfer rates up to 2 Mbaud fit this limit.

Top module: `addr_spi_slave`

## Requirements
- R1: While `rst_n` is low, `so_oe` is low, even in the middle of a frame. After reset every configuration word on `cfg_q` is zero.
- R2: `so_oe` is low whenever `ss_n` has been high for the synchroniser delay.
- R3: A frame is shifted MSB first, and SI is sampled on rising SCK. The frame is laid out as follows: bits 23:22 are the device address, which is compared with `dev_id`; bit 21 is the direction (1 = read, 0 = write); bits 20:16 are the register address; bits 15:0 are the data. On a mismatch, `so_oe` stays low for the whole frame and no register changes.
- R4: A complete write frame to address 0..3 replaces configuration word N, which appears on `cfg_q[16N+15:16N]` after the frame.
- R5: In a matched read, `so_oe` is high from the third SCK cycle onward. The register value is driven MSB first and changes only after falling SCK, so each data bit is valid at rising edges 9 through 24.
- R6: Addresses 4..5 return status word `status_in[16(A-4)+15:16(A-4)]`, captured when the header completes. Addresses 6..7 return the identification value 16'h5A30 + (A-6). Writes to addresses 4..7 change nothing.
- R7: A frame that `ss_n` ends before the 24th rising SCK edge commits nothing.
- R8: Addresses 16..23 map to result entries 0..7. A one-cycle pulse on `res_wr` stores `res_wdata` in entry `res_idx`. SPI reads return the entry, and SPI writes also replace it.
- R9: Addresses 8..15 and 24..31 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_id | input | 2 | Strapped device address |
| sck | input | 1 | Serial clock from host, idles low |
| ss_n | input | 1 | Active-low slave select |
| si | input | 1 | Serial data from host |
| so_d | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for the SO pad driver |
| status_in | input | 32 | Two read-only status words |
| cfg_q | output | 64 | Four configuration words |
| res_wr | input | 1 | Converter result write strobe |
| res_idx | input | 3 | Result entry index |
| res_wdata | input | 16 | Result value |

## Verification
The assertions assume that SCK and SI are stable for several system clocks around each SCK edge. They also assume that `ss_n` changes only while SCK is low, with at least one half SCK period between the select edge and the first or last clock edge. The bench holds each SCK phase for twelve system clocks and changes SI and `ss_n` only in the low phase. This keeps the oversampled edges and the output shift apart. The random frames mix matched and foreign device addresses, all register addresses, and converter writes placed between frames. The converter port is therefore never active in the same cycle as an SPI commit.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

  localparam int DEV_W = 2;

  typedef enum logic [2:0] {
    RG_CFG,
    RG_STAT,
    RG_ID,
    RG_RES,
    RG_NONE
  } region_e;

  // Classify a register address into its access region.
  function automatic region_e region_of(input int unsigned a,
                                        input int unsigned ncfg,
                                        input int unsigned nstat,
                                        input int unsigned nid,
                                        input int unsigned rbase,
                                        input int unsigned nres);
    if (a < ncfg)                          return RG_CFG;
    else if (a < ncfg + nstat)             return RG_STAT;
    else if (a < ncfg + nstat + nid)       return RG_ID;
    else if (a >= rbase && a < rbase+nres) return RG_RES;
    else                                   return RG_NONE;
  endfunction

  // Identification word i is the base value plus its index.
  function automatic logic [31:0] id_word(input logic [31:0] base,
                                          input int unsigned i);
    return base + i;
  endfunction

  // Total frame length in bits.
  function automatic int unsigned frame_bits(input int unsigned aw,
                                             input int unsigned dw);
    return DEV_W + 1 + aw + dw;
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic ss_n,
  input  logic si,
  output logic ss_act,
  output logic si_s,
  output logic sck_rise,
  output logic sck_fall
);

  logic [STAGES-1:0] sck_p;
  logic [STAGES-1:0] ss_p;
  logic [STAGES-1:0] si_p;
  logic              sck_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_p <= '0;
          ss_p  <= '1;
          si_p  <= '0;
        end else begin
          sck_p <= sck;
          ss_p  <= ss_n;
          si_p  <= si;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_p <= '0;
          ss_p  <= '1;
          si_p  <= '0;
        end else begin
          sck_p <= {sck_p[STAGES-2:0], sck};
          ss_p  <= {ss_p[STAGES-2:0], ss_n};
          si_p  <= {si_p[STAGES-2:0], si};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_p[STAGES-1];
  end

  assign ss_act   = ~ss_p[STAGES-1];
  assign si_s     = si_p[STAGES-1];
  assign sck_rise = ss_act &  sck_p[STAGES-1] & ~sck_d;
  assign sck_fall = ss_act & ~sck_p[STAGES-1] &  sck_d;

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_regif_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEV_W-1:0]  dev_id,
  input  logic              ss_act,
  input  logic              si_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_en,
  output logic              dev_hit,
  output logic              frame_full,
  output logic              so_d,
  output logic              so_oe
);

  localparam int HDR_LEN   = DEV_W + 1 + ADDR_W;
  localparam int FRAME_LEN = frame_bits(ADDR_W, DATA_W);
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  logic [CNT_W-1:0]     cnt;
  logic [FRAME_LEN-1:0] shreg;
  logic                 is_rd;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    tx_q;
  logic                 so_q;
  logic                 load_q;
  logic                 wr_q;
  logic                 hit_q;

  logic [DEV_W-1:0]     dev_next;
  logic [ADDR_W-1:0]    addr_next;

  assign dev_next  = {shreg[DEV_W-2:0], si_s};
  assign addr_next = {shreg[ADDR_W-2:0], si_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      shreg  <= '0;
      is_rd  <= 1'b0;
      addr_q <= '0;
      tx_q   <= '0;
      so_q   <= 1'b0;
      load_q <= 1'b0;
      wr_q   <= 1'b0;
      hit_q  <= 1'b0;
    end else if (!ss_act) begin
      cnt    <= '0;
      so_q   <= 1'b0;
      load_q <= 1'b0;
      wr_q   <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      load_q <= 1'b0;
      wr_q   <= 1'b0;
      if (sck_rise && cnt < CNT_W'(FRAME_LEN)) begin
        shreg <= {shreg[FRAME_LEN-2:0], si_s};
        cnt   <= cnt + 1'b1;
        if (cnt == CNT_W'(DEV_W - 1))
          hit_q <= (dev_next == dev_id);
        if (cnt == CNT_W'(DEV_W))
          is_rd <= si_s;
        if (cnt == CNT_W'(HDR_LEN - 1)) begin
          addr_q <= addr_next;
          load_q <= hit_q & is_rd;
        end
        if (cnt == CNT_W'(FRAME_LEN - 1))
          wr_q <= hit_q & ~is_rd;
      end
      if (load_q)
        tx_q <= rd_data;
      if (sck_fall && cnt >= CNT_W'(HDR_LEN)) begin
        so_q <= (cnt < CNT_W'(FRAME_LEN)) ? tx_q[DATA_W-1] : 1'b0;
        tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign reg_addr   = addr_q;
  assign wr_data    = shreg[DATA_W-1:0];
  assign wr_en      = wr_q;
  assign dev_hit    = hit_q;
  assign frame_full = (cnt == CNT_W'(FRAME_LEN));
  assign so_d       = so_q;
  assign so_oe      = hit_q;

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regif_pkg::*;
#(
  parameter int          ADDR_W   = 5,
  parameter int          DATA_W   = 16,
  parameter int          NUM_CFG  = 4,
  parameter int          NUM_STAT = 2,
  parameter int          NUM_ID   = 2,
  parameter int          RES_BASE = 16,
  parameter int          NUM_RES  = 8,
  parameter logic [31:0] ID_BASE  = 32'h5A30,
  localparam int         RES_IDX_W = $clog2(NUM_RES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            rd_data,
  input  logic [NUM_STAT*DATA_W-1:0]   status_in,
  output logic [NUM_CFG*DATA_W-1:0]    cfg_q,
  input  logic                         res_wr,
  input  logic [RES_IDX_W-1:0]         res_idx,
  input  logic [DATA_W-1:0]            res_wdata
);

  logic [DATA_W-1:0] cfg_r [NUM_CFG];
  logic [DATA_W-1:0] res_r [NUM_RES];
  region_e           rg;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_r[g] <= '0;
      else if (wr_en && reg_addr == ADDR_W'(g))
        cfg_r[g] <= wr_data;
    end
    assign cfg_q[g*DATA_W +: DATA_W] = cfg_r[g];
  end

  // Converter port takes priority over a host write to the same entry.
  for (genvar r = 0; r < NUM_RES; r++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        res_r[r] <= '0;
      else if (res_wr && res_idx == RES_IDX_W'(r))
        res_r[r] <= res_wdata;
      else if (wr_en && reg_addr == ADDR_W'(RES_BASE + r))
        res_r[r] <= wr_data;
    end
  end

  always_comb begin
    rg      = region_of(int'(reg_addr), NUM_CFG, NUM_STAT, NUM_ID,
                        RES_BASE, NUM_RES);
    rd_data = '0;
    unique case (rg)
      RG_CFG: begin
        for (int i = 0; i < NUM_CFG; i++)
          if (reg_addr == ADDR_W'(i)) rd_data = cfg_r[i];
      end
      RG_STAT: begin
        for (int i = 0; i < NUM_STAT; i++)
          if (reg_addr == ADDR_W'(NUM_CFG + i))
            rd_data = status_in[i*DATA_W +: DATA_W];
      end
      RG_ID: begin
        for (int i = 0; i < NUM_ID; i++)
          if (reg_addr == ADDR_W'(NUM_CFG + NUM_STAT + i))
            rd_data = DATA_W'(id_word(ID_BASE, i));
      end
      RG_RES: begin
        for (int i = 0; i < NUM_RES; i++)
          if (reg_addr == ADDR_W'(RES_BASE + i)) rd_data = res_r[i];
      end
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/addr_spi_slave.sv
module addr_spi_slave
  import spi_regif_pkg::*;
#(
  parameter int          ADDR_W      = 5,
  parameter int          DATA_W      = 16,
  parameter int          NUM_CFG     = 4,
  parameter int          NUM_STAT    = 2,
  parameter int          NUM_ID      = 2,
  parameter int          RES_BASE    = 16,
  parameter int          NUM_RES     = 8,
  parameter logic [31:0] ID_BASE     = 32'h5A30,
  parameter int          SYNC_STAGES = 2,
  localparam int         RES_IDX_W   = $clog2(NUM_RES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DEV_W-1:0]           dev_id,
  input  logic                       sck,
  input  logic                       ss_n,
  input  logic                       si,
  output logic                       so_d,
  output logic                       so_oe,
  input  logic [NUM_STAT*DATA_W-1:0] status_in,
  output logic [NUM_CFG*DATA_W-1:0]  cfg_q,
  input  logic                       res_wr,
  input  logic [RES_IDX_W-1:0]       res_idx,
  input  logic [DATA_W-1:0]          res_wdata
);

  logic              ss_act;
  logic              si_s;
  logic              sck_rise;
  logic              sck_fall;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              wr_en;
  logic              dev_hit;
  logic              frame_full;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .ss_n     (ss_n),
    .si       (si),
    .ss_act   (ss_act),
    .si_s     (si_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  spi_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_id     (dev_id),
    .ss_act     (ss_act),
    .si_s       (si_s),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .rd_data    (rd_data),
    .reg_addr   (reg_addr),
    .wr_data    (wr_data),
    .wr_en      (wr_en),
    .dev_hit    (dev_hit),
    .frame_full (frame_full),
    .so_d       (so_d),
    .so_oe      (so_oe)
  );

  spi_reg_bank #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_CFG  (NUM_CFG),
    .NUM_STAT (NUM_STAT),
    .NUM_ID   (NUM_ID),
    .RES_BASE (RES_BASE),
    .NUM_RES  (NUM_RES),
    .ID_BASE  (ID_BASE)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .reg_addr  (reg_addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .status_in (status_in),
    .cfg_q     (cfg_q),
    .res_wr    (res_wr),
    .res_idx   (res_idx),
    .res_wdata (res_wdata)
  );

endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk #(
  parameter int CFG_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ss_n,
  input logic             so_oe,
  input logic             so_d,
  input logic             sck_fall,
  input logic             ss_act,
  input logic             wr_en,
  input logic             frame_full,
  input logic [CFG_W-1:0] cfg_q
);

  // R1
  oe_in_reset_chk: assert property (@(posedge clk) !rst_n |-> !so_oe);

  // R2
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $past(ss_n) && $past(ss_n, 2) && $past(ss_n, 3)) |-> !so_oe);

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

  // R5
  so_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so_d) |-> ($past(sck_fall) || !$past(ss_act)));

  // R7
  commit_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (frame_full && ss_act));

endmodule

bind addr_spi_slave spi_regif_chk #(.CFG_W(NUM_CFG*DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ss_n       (ss_n),
  .so_oe      (so_oe),
  .so_d       (so_d),
  .sck_fall   (sck_fall),
  .ss_act     (ss_act),
  .wr_en      (wr_en),
  .frame_full (frame_full),
  .cfg_q      (cfg_q)
);

// File: tb/addr_spi_slave_tb.sv
module addr_spi_slave_tb;

  localparam int          HP     = 12;
  localparam logic [1:0]  MY_DEV = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0;
  logic        ss_n = 1'b1;
  logic        si = 1'b0;
  logic        so_d;
  logic        so_oe;
  logic [31:0] status_in = '0;
  logic [63:0] cfg_q;
  logic        res_wr = 1'b0;
  logic [2:0]  res_idx = '0;
  logic [15:0] res_wdata = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] cfg_m [4];
  logic [15:0] res_m [8];

  always #10 clk = ~clk;

  addr_spi_slave u_dut (
    .clk(clk), .rst_n(rst_n), .dev_id(MY_DEV), .sck(sck), .ss_n(ss_n),
    .si(si), .so_d(so_d), .so_oe(so_oe), .status_in(status_in),
    .cfg_q(cfg_q), .res_wr(res_wr), .res_idx(res_idx),
    .res_wdata(res_wdata)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [4:0] a);
    if (a < 5'd4)                    return cfg_m[a[1:0]];
    else if (a == 5'd4)              return status_in[15:0];
    else if (a == 5'd5)              return status_in[31:16];
    else if (a == 5'd6 || a == 5'd7) return 16'h5A30 + 16'(a - 5'd6);
    else if (a >= 5'd16 && a < 5'd24) return res_m[a[2:0]];
    else                             return 16'h0000;
  endfunction

  function automatic logic [63:0] cfg_pack();
    return {cfg_m[3], cfg_m[2], cfg_m[1], cfg_m[0]};
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    if (a < 5'd4)                     return "R5";
    else if (a < 5'd8)                return "R6";
    else if (a >= 5'd16 && a < 5'd24) return "R8";
    else                              return "R9";
  endfunction

  task automatic model_write(input logic [4:0] a, input logic [15:0] d);
    if (a < 5'd4) cfg_m[a[1:0]] = d;
    else if (a >= 5'd16 && a < 5'd24) res_m[a[2:0]] = d;
  endtask

  task automatic xfer(input logic [1:0] dv, input logic rd,
                      input logic [4:0] a, input logic [15:0] wd,
                      input int nbits, output logic [15:0] rdat,
                      output logic oe_hi, output logic oe_lo);
    logic [23:0] f;
    f = {dv, rd, a, wd};
    rdat = '0;
    oe_hi = 1'b1;
    oe_lo = 1'b1;
    @(negedge clk);
    sck = 1'b0;
    ss_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      si = f[23-i];
      repeat (HP) @(negedge clk);
      if (i >= 2 && so_oe !== 1'b1) oe_hi = 1'b0;
      if (so_oe !== 1'b0) oe_lo = 1'b0;
      if (i >= 8) rdat[23-i] = so_d;
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HP) @(negedge clk);
    ss_n = 1'b1;
    repeat (2*HP) @(negedge clk);
  endtask

  task automatic conv_write(input logic [2:0] idx, input logic [15:0] d);
    @(negedge clk);
    res_wr = 1'b1;
    res_idx = idx;
    res_wdata = d;
    @(negedge clk);
    res_wr = 1'b0;
    res_m[idx] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic oh, ol;
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) cfg_m[i] = '0;
    for (int i = 0; i < 8; i++) res_m[i] = '0;

    repeat (3) @(negedge clk);
    chk(so_oe === 1'b0, "R1 oe in reset", 64'(so_oe), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cfg_q === 64'h0, "R1 cfg after reset", cfg_q, 0);
    chk(so_oe === 1'b0, "R2 oe idle", 64'(so_oe), 0);

    // R4 directed write then R5 readback
    xfer(MY_DEV, 1'b0, 5'd2, 16'hBEEF, 24, rd, oh, ol);
    model_write(5'd2, 16'hBEEF);
    chk(cfg_q === cfg_pack(), "R4 cfg write", cfg_q, cfg_pack());
    xfer(MY_DEV, 1'b1, 5'd2, 16'h0, 24, rd, oh, ol);
    chk(rd === 16'hBEEF, "R5 read data", 64'(rd), 64'hBEEF);
    chk(oh === 1'b1, "R5 oe during read", 64'(oh), 1);
    chk(so_oe === 1'b0, "R2 oe after frame", 64'(so_oe), 0);

    // R3 foreign address: no drive, no write
    xfer(~MY_DEV, 1'b0, 5'd2, 16'h1234, 24, rd, oh, ol);
    chk(ol === 1'b1, "R3 foreign oe low", 64'(ol), 1);
    chk(cfg_q === cfg_pack(), "R3 foreign no write", cfg_q, cfg_pack());

    // R7 aborted write
    xfer(MY_DEV, 1'b0, 5'd1, 16'h7777, 23, rd, oh, ol);
    chk(cfg_q === cfg_pack(), "R7 abort no commit", cfg_q, cfg_pack());

    // R6 read-only words
    status_in = 32'hCAFE_0F0F;
    xfer(MY_DEV, 1'b0, 5'd6, 16'h0000, 24, rd, oh, ol);
    xfer(MY_DEV, 1'b1, 5'd6, 16'h0, 24, rd, oh, ol);
    chk(rd === 16'h5A30, "R6 id after write", 64'(rd), 64'h5A30);
    xfer(MY_DEV, 1'b1, 5'd7, 16'h0, 24, rd, oh, ol);
    chk(rd === 16'h5A31, "R6 id word 1", 64'(rd), 64'h5A31);
    xfer(MY_DEV, 1'b0, 5'd5, 16'h0000, 24, rd, oh, ol);
    xfer(MY_DEV, 1'b1, 5'd5, 16'h0, 24, rd, oh, ol);
    chk(rd === 16'hCAFE, "R6 status word", 64'(rd), 64'hCAFE);

    // R8 result memory
    conv_write(3'd5, 16'h03FF);
    xfer(MY_DEV, 1'b1, 5'd21, 16'h0, 24, rd, oh, ol);
    chk(rd === 16'h03FF, "R8 converter entry", 64'(rd), 64'h3FF);
    xfer(MY_DEV, 1'b0, 5'd16, 16'hA5A5, 24, rd, oh, ol);
    model_write(5'd16, 16'hA5A5);
    xfer(MY_DEV, 1'b1, 5'd16, 16'h0, 24, rd, oh, ol);
    chk(rd === 16'hA5A5, "R8 host entry", 64'(rd), 64'hA5A5);

    // R9 unmapped
    xfer(MY_DEV, 1'b0, 5'd10, 16'hFFFF, 24, rd, oh, ol);
    xfer(MY_DEV, 1'b1, 5'd10, 16'h0, 24, rd, oh, ol);
    chk(rd === 16'h0000, "R9 unmapped read", 64'(rd), 0);
    chk(cfg_q === cfg_pack(), "R9 unmapped no write", cfg_q, cfg_pack());

    // random frames
    for (int k = 0; k < 60; k++) begin
      logic [1:0]  dv;
      logic        rw;
      logic [4:0]  a;
      logic [15:0] d;
      dv = ($urandom % 4 == 0) ? 2'($urandom % 4) : MY_DEV;
      rw = 1'($urandom % 2);
      a  = 5'($urandom % 32);
      d  = 16'($urandom);
      status_in = $urandom;
      if ($urandom % 3 == 0) conv_write(3'($urandom % 8), 16'($urandom % 1024));
      xfer(dv, rw, a, d, 24, rd, oh, ol);
      if (dv == MY_DEV) begin
        chk(oh === 1'b1, "R5 oe matched", 64'(oh), 1);
        if (rw) chk(rd === exp_read(a), tag_of(a), 64'(rd), 64'(exp_read(a)));
        else model_write(a, d);
      end else begin
        chk(ol === 1'b1, "R3 foreign oe low", 64'(ol), 1);
      end
      chk(cfg_q === cfg_pack(), "R4 cfg model", cfg_q, cfg_pack());
    end

    // R1 reset in the middle of a matched frame
    @(negedge clk);
    ss_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      si = (i == 0) ? MY_DEV[1] : (i == 1) ? MY_DEV[0] : 1'b0;
      repeat (HP) @(negedge clk);
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HP) @(negedge clk);
    chk(so_oe === 1'b1, "R3 matched oe mid frame", 64'(so_oe), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(so_oe === 1'b0, "R1 oe reset mid frame", 64'(so_oe), 0);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cfg_m[i] = '0;
    for (int i = 0; i < 8; i++) res_m[i] = '0;
    repeat (4) @(negedge clk);
    chk(cfg_q === 64'h0, "R1 cfg cleared", cfg_q, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule